// File: doc/BRIEF.md
# Daisy-Chainable TDM Output Serializer

This block converts one stereo sample pair into a serial time-division-multiplexed bit stream. A one-cycle frame strobe copies the left and right samples in parallel into a 64-bit shift register. Each one-cycle bit-clock enable then moves the register one place toward its most significant end. The bit leaving the top drives the serial output, and the bit entering the bottom comes from a cascade input.

Units can be placed in series by wiring each unit's serial output to the next unit's cascade input. All units share the frame strobe and the bit-clock enable, so the chain acts as one long register. The unit at the far end sends its own 64 bits first, followed by the 64-bit slots of the units behind it. Each unit needs 64 bit clocks per frame. For example, eight units need a bit clock of 512 times the sample rate, and the achievable bit-clock rate limits how long a chain can be.

A 2-bit width code picks 24, 20, 18 or 16 significant bits for both samples. The code is applied at load time by clearing the sample bits below the chosen width.

Top module: `tdm_chain_serializer`

## Requirements
- R1: While reset is asserted, and until the first load after reset, `sdata_out` is 0 and the whole register holds zero. Shifting it out with `cascade_in` held at 0 gives 64 zero bits.
- R2: After a load, the frame leaves MSB first. The left sample occupies register bits 63:32 and the right sample bits 31:0, each left-justified, so sample bit 23 of the left channel is the first bit out.
- R3: With `width_sel` = 2'b00 at the load, all 24 bits of each sample are sent unchanged.
- R4: With `width_sel` = 2'b01 at the load, sample bits 3:0 of both channels go out as 0, which keeps 20 bits.
- R5: With `width_sel` = 2'b10 at the load, sample bits 5:0 of both channels go out as 0, which keeps 18 bits.
- R6: With `width_sel` = 2'b11 at the load, sample bits 7:0 of both channels go out as 0, which keeps 16 bits.
- R7: The 8 pad bits below each 24-bit sample slot (register bits 39:32 and 7:0) are loaded as 0.
- R8: Each enabled bit clock shifts `cascade_in` into register bit 0. A bit presented there appears on `sdata_out` exactly 64 enabled shifts later, so two chained units form a 128-bit frame followed by the upstream data.
- R9: With neither strobe asserted, the register and `sdata_out` hold their value.
- R10: When `frame_ld` and `bit_en` are asserted in the same cycle, the load takes place and the shift does not.
- R11: Changes on `width_sel`, `left_smp` and `right_smp` between loads have no effect on the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| bit_en | input | 1 | Single-cycle bit-clock enable; shifts the register by one place |
| frame_ld | input | 1 | Single-cycle frame strobe; loads both samples in parallel |
| width_sel | input | 2 | Output word width: 00=24, 01=20, 10=18, 11=16 bits |
| left_smp | input | 24 | Left-channel sample |
| right_smp | input | 24 | Right-channel sample |
| cascade_in | input | 1 | Serial input from the previous unit in the chain |
| sdata_out | output | 1 | Serial output, register bit 63 |

## Verification
The bench chains two units and sweeps all four width codes. For each code it uses several sample patterns: all ones, alternating bits, and arithmetic sequences that differ between the two units and the two channels. With all-ones samples, any error in where the cleared low bits begin shows up. The distinct per-unit and per-channel values show whether the slot order or the channel order is wrong. A known cascade pattern is fed behind each frame, which measures the 128-shift delay through the chain.

Some runs leave idle cycles between shifts, to check that the output holds between enables. Some runs alter the width code and the sample inputs while the frame is being shifted out. Every load also coincides with an active bit enable and a 1 on the cascade input, which shows whether the load takes priority over the shift.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

  // Output word width selection code
  typedef enum logic [1:0] {
    WSEL_24 = 2'b00,
    WSEL_20 = 2'b01,
    WSEL_18 = 2'b10,
    WSEL_16 = 2'b11
  } wsel_e;

  // Number of sample LSBs cleared for each width code
  function automatic logic [4:0] drop_for(wsel_e sel);
    case (sel)
      WSEL_24: drop_for = 5'd0;
      WSEL_20: drop_for = 5'd4;
      WSEL_18: drop_for = 5'd6;
      default: drop_for = 5'd8;
    endcase
  endfunction

endpackage

// File: rtl/tdm_rst_sync.sv
module tdm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/tdm_word_trim.sv
module tdm_word_trim
  import tdm_ser_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic [1:0]          wsel,
  input  logic [SAMPLE_W-1:0] smp_in,
  output logic [SAMPLE_W-1:0] smp_out
);

  logic [4:0]          drop_cnt;
  logic [SAMPLE_W-1:0] keep_mask;

  always_comb begin
    drop_cnt = drop_for(wsel_e'(wsel));
  end

  // One keep bit per sample position: kept when at or above the drop count
  for (genvar g = 0; g < SAMPLE_W; g++) begin : g_mask
    assign keep_mask[g] = (5'(g) >= drop_cnt);
  end

  assign smp_out = smp_in & keep_mask;

endmodule

// File: rtl/tdm_frame_shifter.sv
module tdm_frame_shifter #(
  parameter int FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               shift_en,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               ser_in,
  output logic [FRAME_W-1:0] frame_q,
  output logic               ser_out
);

  logic [FRAME_W-1:0] frame_d;
  logic               frame_en;

  // Next-state: load has priority over shift
  always_comb begin
    frame_en = load_en | shift_en;
    if (load_en) begin
      frame_d = load_word;
    end else if (shift_en) begin
      frame_d = {frame_q[FRAME_W-2:0], ser_in};
    end else begin
      frame_d = frame_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (frame_en) begin
      frame_q <= frame_d;
    end
  end

  assign ser_out = frame_q[FRAME_W-1];

endmodule

// File: rtl/tdm_chain_serializer.sv
module tdm_chain_serializer #(
  parameter int SAMPLE_W    = 24,
  parameter int HALF_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic                frame_ld,
  input  logic [1:0]          width_sel,
  input  logic [SAMPLE_W-1:0] left_smp,
  input  logic [SAMPLE_W-1:0] right_smp,
  input  logic                cascade_in,
  output logic                sdata_out
);

  localparam int PAD_W   = HALF_W - SAMPLE_W;
  localparam int FRAME_W = 2 * HALF_W;
  localparam int N_CH    = 2;

  logic                       core_rst_n;
  logic [N_CH-1:0][SAMPLE_W-1:0] raw_smp;
  logic [N_CH-1:0][SAMPLE_W-1:0] trim_smp;
  logic [FRAME_W-1:0]         load_word;
  logic [FRAME_W-1:0]         frame_q;

  tdm_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(core_rst_n)
  );

  // Channel 1 is left (upper half), channel 0 is right (lower half)
  assign raw_smp[1] = left_smp;
  assign raw_smp[0] = right_smp;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    tdm_word_trim #(
      .SAMPLE_W(SAMPLE_W)
    ) u_trim (
      .wsel   (width_sel),
      .smp_in (raw_smp[c]),
      .smp_out(trim_smp[c])
    );
    assign load_word[c*HALF_W +: HALF_W] = {trim_smp[c], {PAD_W{1'b0}}};
  end

  tdm_frame_shifter #(
    .FRAME_W(FRAME_W)
  ) u_shifter (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .load_en  (frame_ld),
    .shift_en (bit_en),
    .load_word(load_word),
    .ser_in   (cascade_in),
    .frame_q  (frame_q),
    .ser_out  (sdata_out)
  );

endmodule

// File: rtl/tdm_chain_serializer_chk.sv
module tdm_chain_serializer_chk #(
  parameter int SAMPLE_W = 24,
  parameter int HALF_W   = 32,
  parameter int FRAME_W  = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                core_rst_n,
  input logic                bit_en,
  input logic                frame_ld,
  input logic [1:0]          width_sel,
  input logic [SAMPLE_W-1:0] left_smp,
  input logic [SAMPLE_W-1:0] right_smp,
  input logic                cascade_in,
  input logic [FRAME_W-1:0]  frame_q
);

  localparam int PAD_W = HALF_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] left_f;
  logic [SAMPLE_W-1:0] right_f;
  logic [PAD_W-1:0]    left_pad;
  logic [PAD_W-1:0]    right_pad;

  assign left_f    = frame_q[FRAME_W-1 -: SAMPLE_W];
  assign right_f   = frame_q[HALF_W-1 -: SAMPLE_W];
  assign left_pad  = frame_q[HALF_W +: PAD_W];
  assign right_pad = frame_q[0 +: PAD_W];

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> frame_q == '0);

  p_msb_first_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    frame_ld |=> (frame_q[FRAME_W-1] == $past(left_smp[SAMPLE_W-1]))
              && (frame_q[HALF_W-1] == $past(right_smp[SAMPLE_W-1])));

  p_full_width_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (frame_ld && width_sel == 2'b00) |=>
      (left_f == $past(left_smp)) && (right_f == $past(right_smp)));

  p_trim20_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (frame_ld && width_sel == 2'b01) |=> ((left_f | right_f) & SAMPLE_W'(4'hF)) == '0);

  p_trim18_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (frame_ld && width_sel == 2'b10) |=> ((left_f | right_f) & SAMPLE_W'(6'h3F)) == '0);

  p_trim16_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (frame_ld && width_sel == 2'b11) |=> ((left_f | right_f) & SAMPLE_W'(8'hFF)) == '0);

  p_pad_zero_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    frame_ld |=> (left_pad == '0) && (right_pad == '0));

  p_shift_in_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bit_en && !frame_ld) |=>
      frame_q == {$past(frame_q[FRAME_W-2:0]), $past(cascade_in)});

  p_hold_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!bit_en && !frame_ld) |=> $stable(frame_q));

  p_load_priority_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    (frame_ld && bit_en) |=> frame_q[0] == 1'b0);

endmodule

bind tdm_chain_serializer tdm_chain_serializer_chk #(
  .SAMPLE_W(SAMPLE_W),
  .HALF_W  (HALF_W),
  .FRAME_W (FRAME_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .core_rst_n(core_rst_n),
  .bit_en    (bit_en),
  .frame_ld  (frame_ld),
  .width_sel (width_sel),
  .left_smp  (left_smp),
  .right_smp (right_smp),
  .cascade_in(cascade_in),
  .frame_q   (frame_q)
);

// File: tb/tdm_chain_serializer_bench.sv
module tdm_chain_serializer_bench;

  localparam int SW = 24;

  logic          clk;
  logic          rst_n;
  logic          bit_en;
  logic          frame_ld;
  logic [1:0]    width_sel;
  logic [SW-1:0] la, ra, lb, rb;
  logic          cascade_in;
  logic          link;
  logic          sdata_out;

  int checks;
  int fails;
  bit done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Unit A receives the bench cascade; unit B drives the final output
  tdm_chain_serializer u_tdm_chain_serializer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_ld(frame_ld),
    .width_sel(width_sel), .left_smp(la), .right_smp(ra),
    .cascade_in(cascade_in), .sdata_out(link)
  );

  tdm_chain_serializer u_tdm_chain_serializer_b (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_ld(frame_ld),
    .width_sel(width_sel), .left_smp(lb), .right_smp(rb),
    .cascade_in(link), .sdata_out(sdata_out)
  );

  function automatic logic [31:0] exp_half(logic [SW-1:0] s, logic [1:0] w);
    int drop;
    logic [SW-1:0] m;
    drop = (w == 2'd0) ? 0 : (w == 2'd1) ? 4 : (w == 2'd2) ? 6 : 8;
    m = s;
    for (int i = 0; i < drop; i++) m[i] = 1'b0;
    return {m, 8'h00};
  endfunction

  function automatic logic cbit(int j);
    return ((j * 13 + (j >> 3)) % 3) == 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic run_frame(input logic [SW-1:0] l_a, r_a, l_b, r_b,
                           input logic [1:0] w, input bit gaps, input bit chg,
                           input string req);
    logic [63:0] ea, eb, ca, cb;
    logic [31:0] cc, ec;
    int hold_bad;
    ea = {exp_half(l_a, w), exp_half(r_a, w)};
    eb = {exp_half(l_b, w), exp_half(r_b, w)};
    hold_bad = 0;
    @(negedge clk);
    la = l_a; ra = r_a; lb = l_b; rb = r_b; width_sel = w;
    frame_ld = 1'b1; bit_en = 1'b1; cascade_in = 1'b1; // R10: load beats shift
    for (int i = 0; i < 160; i++) begin
      @(negedge clk);
      frame_ld = 1'b0;
      if (i < 64) cb[63-i] = sdata_out;
      else if (i < 128) ca[127-i] = sdata_out;
      else cc[159-i] = sdata_out;
      if (chg) begin // R11: inputs changed after the load are ignored
        width_sel = ~w; la = ~l_a; ra = l_b; lb = r_a; rb = ~r_b;
      end
      if (gaps) begin // R9: idle cycle must hold the output
        bit_en = 1'b0; cascade_in = ~cascade_in;
        @(negedge clk);
        if (sdata_out != ((i < 64) ? cb[63-i] : (i < 128) ? ca[127-i] : cc[159-i]))
          hold_bad++;
      end
      bit_en = 1'b1;
      cascade_in = cbit(i);
    end
    @(negedge clk);
    bit_en = 1'b0;
    for (int j = 0; j < 32; j++) ec[31-j] = cbit(j);
    check(cb == eb, req, "downstream slot (R2 R7)", cb, eb);
    check(ca == ea, req, "upstream slot (R2 R8)", ca, ea);
    check(cc == ec, "R8", "cascade after 128 shifts", {32'h0, cc}, {32'h0, ec});
    if (gaps) check(hold_bad == 0, "R9", "hold between enables", 64'(hold_bad), 64'd0);
  endtask

  initial begin
    logic [63:0] z;
    string rq;
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; bit_en = 1'b0; frame_ld = 1'b0; width_sel = 2'b00;
    la = '0; ra = '0; lb = '0; rb = '0; cascade_in = 1'b0;
    repeat (3) @(negedge clk);
    check(sdata_out == 1'b0, "R1", "output in reset", {63'h0, sdata_out}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sdata_out == 1'b0, "R1", "output after reset", {63'h0, sdata_out}, 64'h0);
    // R1: shift both cleared registers out with zero cascade
    z = '0;
    bit_en = 1'b1;
    for (int i = 0; i < 128; i++) begin
      if (sdata_out) z[i % 64] = 1'b1;
      @(negedge clk);
    end
    bit_en = 1'b0;
    check(z == '0, "R1", "cleared register contents", z, 64'h0);

    for (int w = 0; w < 4; w++) begin
      rq = (w == 0) ? "R3" : (w == 1) ? "R4" : (w == 2) ? "R5" : "R6";
      for (int p = 0; p < 6; p++) begin
        logic [SW-1:0] a0, a1, b0, b1;
        case (p)
          0: begin a0 = '1; a1 = '1; b0 = '1; b1 = '1; end
          1: begin a0 = 24'hAAAAAA; a1 = 24'h555555; b0 = 24'h555555; b1 = 24'hAAAAAA; end
          default: begin
            a0 = SW'(32'h9E3779 * (p + w + 1));
            a1 = SW'(32'h7F4A7C * (p + 3));
            b0 = SW'(32'h2545F4 * (p * 5 + w));
            b1 = SW'(32'hC13FA9 ^ (p << (w * 3)));
          end
        endcase
        run_frame(a0, a1, b0, b1, 2'(w), p[0], p >= 3, rq);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule